// File: doc/BRIEF.md
# Security-gated coprocessor access control

This block holds two 32-bit system control registers behind a small request port. The first is the grant register, which only Secure software can change. Its three live bits allow Non-secure software to use coprocessor 10 and coprocessor 11, and one bit can force Non-secure SIMD off. The second is the coprocessor access register. It holds a two-bit access field for each of the two coprocessors and a SIMD-disable bit. When the processor is in Non-secure state, the grant register masks what software sees of these fields and what it can change in them.

Each request is sorted into one access kind in the same cycle it is presented. The kinds are NONE (no request), READ, WRITE, RD_FIXED (a Non-secure read that returns a constant), TRAP (the access is sent to the top exception level) and UNDEF (the access is refused). The sort uses the exception level, the security state and a flag that says whether the top exception level runs in 64-bit state. The read data, trap flag and undefined flag follow the chosen kind in the same cycle. An accepted write is stored at the next clock edge.

The block also drives one Non-secure enable line per coprocessor. When the processor is in Non-secure state and uses a coprocessor that is not enabled, the block raises a separate undefined-instruction flag.

Top module: `cp_secgate`

## Requirements
- R1: After reset, every stored control bit is 0. A Secure read of either register returns 0, and both coprocessor enables are 0 while `ns_state` is 1.
- R2: In the grant register, bit 15 is the Non-secure SIMD disable, bit 11 is the coprocessor 11 grant and bit 10 is the coprocessor 10 grant. Every other bit, including bit 20, reads as 0 and ignores writes.
- R3: Any access from exception level 0 (`cur_el`=0) sets `rsp_undef`. It changes neither register.
- R4: Only Secure software at `cur_el` 1 to 3 may write the grant register. A write from Non-secure state sets `rsp_undef` and is ignored, while reads from Non-secure EL1 to EL3 are allowed.
- R5: When `top_el_64` is 1, any access to the grant register from Secure EL1 sets `rsp_trap` instead of completing, and the register does not change.
- R6: When `top_el_64` is 1, a read of the grant register from Non-secure EL1 or EL2 returns 0x00000C00. Non-secure EL3 reads, and any read while `top_el_64` is 0, return the stored value.
- R7: In the access register, the coprocessor 10 field is bits 21:20 and the coprocessor 11 field is bits 23:22. When `ns_state` is 1 and the matching grant bit is 0, that field reads as 00 and Non-secure writes to it are ignored.
- R8: In the access register, bit 31 is the SIMD disable. When `ns_state` is 1 and grant bit 15 is 1, bit 31 reads as 1 and Non-secure writes to it are ignored.
- R9: A Secure access to the access register reads and writes all three fields unmasked. All other bits of the access register read as 0.
- R10: An accepted write takes effect at the next clock edge, so a read in the following cycle returns the new value.
- R11: `cp_ns_en[0]` belongs to coprocessor 10 and `cp_ns_en[1]` to coprocessor 11. Each equals its grant bit while `ns_state` is 1 and is 1 while `ns_state` is 0.
- R12: `use_undef` is 1 when, in Non-secure state, `cp_use` marks a coprocessor whose enable is 0.
- R13: In the cycle of a write, a trap or a refused access, and when there is no request, `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_sel | input | 1 | 0 selects the grant register, 1 selects the access register |
| req_wdata | input | 32 | Write data |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| ns_state | input | 1 | 1 when the processor is in Non-secure state |
| top_el_64 | input | 1 | 1 when the top exception level runs in 64-bit state |
| cp_use | input | 2 | Coprocessor use this cycle: bit 0 for coprocessor 10, bit 1 for coprocessor 11 |
| rsp_rdata | output | 32 | Read data for the current request |
| rsp_trap | output | 1 | The access is trapped to the top exception level |
| rsp_undef | output | 1 | The register access is refused |
| cp_ns_en | output | 2 | Per-coprocessor enable |
| use_undef | output | 1 | A coprocessor that is not enabled was used |

## Verification
A wrong stored grant bit shows up within a cycle in three places: the enable outputs, the masked fields of the access register, and a Secure read-back of the grant register. A write that should have been refused, but that changed a register anyway, shows up on the very next Secure read of that register. A wrong access kind shows at the ports in the same cycle as the request, on the trap flag, on the undefined flag or on the read data. The bench therefore sets each of the eight grant values in turn. For each one it sweeps every combination of exception level, security state, top-level mode, register and direction, and it reads both registers back after every access.

// File: rtl/cp_secgate_pkg.sv
`timescale 1ns/1ps
package cp_secgate_pkg;
    localparam int DW = 32;
    localparam int NUM_CP = 2;
    // grant register bit positions
    localparam int G_CP10 = 10;
    localparam int G_CP11 = 11;
    localparam int G_SIMD = 15;
    // access register field positions
    localparam int A_CP10_LO = 20;
    localparam int A_CP11_LO = 22;
    localparam int A_SIMD = 31;
    localparam logic [DW-1:0] NS_FIXED_RD = 32'h0000_0C00;
    localparam logic [DW-1:0] GRANT_MASK = (DW'(1) << G_CP10) | (DW'(1) << G_CP11) | (DW'(1) << G_SIMD);
    localparam logic [DW-1:0] CPACC_MASK = (DW'(3) << A_CP10_LO) | (DW'(3) << A_CP11_LO) | (DW'(1) << A_SIMD);

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_RD_FIXED,
        ACC_TRAP,
        ACC_UNDEF
    } acc_kind_e;

    typedef struct packed {
        logic simd_dis;
        logic cp11;
        logic cp10;
    } grant_t;

    typedef struct packed {
        logic       simd_dis;
        logic [1:0] cp11;
        logic [1:0] cp10;
    } cpacc_t;
endpackage

// File: rtl/cp_secgate_decode.sv
`timescale 1ns/1ps
module cp_secgate_decode
    import cp_secgate_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_sel,
    input  logic [1:0] cur_el,
    input  logic       ns_state,
    input  logic       top_el_64,
    output acc_kind_e  kind
);
    always_comb begin
        kind = ACC_NONE;
        if (req_valid) begin
            if (cur_el == 2'd0) begin
                kind = ACC_UNDEF;
            end else if (req_sel) begin
                kind = req_write ? ACC_WRITE : ACC_READ;
            end else if (!ns_state && top_el_64 && cur_el == 2'd1) begin
                kind = ACC_TRAP;
            end else if (ns_state) begin
                if (req_write)
                    kind = ACC_UNDEF;
                else if (top_el_64 && cur_el != 2'd3)
                    kind = ACC_RD_FIXED;
                else
                    kind = ACC_READ;
            end else begin
                kind = req_write ? ACC_WRITE : ACC_READ;
            end
        end
    end

    // R4: no Non-secure write of the grant register is ever accepted
    always_comb begin
        assert_ns_grant_wr_R4: assert (!(kind == ACC_WRITE && !req_sel && ns_state));
    end
endmodule

// File: rtl/cp_secgate_grant.sv
`timescale 1ns/1ps
module cp_secgate_grant
    import cp_secgate_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  grant_t wdata,
    output grant_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end

    // R10: a write request is reflected in the stored bits one edge later
    assert_grant_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata)));
endmodule

// File: rtl/cp_secgate_cpacc.sv
`timescale 1ns/1ps
module cp_secgate_cpacc
    import cp_secgate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  cpacc_t        wdata,
    input  logic          ns_state,
    input  grant_t        grant,
    output cpacc_t        q,
    output logic [DW-1:0] rview
);
    cpacc_t nxt;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            if (!ns_state) begin
                nxt = wdata;
            end else begin
                if (grant.cp10)      nxt.cp10 = wdata.cp10;
                if (grant.cp11)      nxt.cp11 = wdata.cp11;
                if (!grant.simd_dis) nxt.simd_dis = wdata.simd_dis;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= nxt;
    end

    always_comb begin
        rview = '0;
        rview[A_CP10_LO +: 2] = (ns_state && !grant.cp10) ? 2'b00 : q.cp10;
        rview[A_CP11_LO +: 2] = (ns_state && !grant.cp11) ? 2'b00 : q.cp11;
        rview[A_SIMD]         = (ns_state && grant.simd_dis) ? 1'b1 : q.simd_dis;
    end

    // R7: hidden fields read zero and are not written from Non-secure state
    assert_hide_cp10_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_state && !grant.cp10) |-> (rview[A_CP10_LO +: 2] == 2'b00));
    assert_keep_cp11_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ns_state && !grant.cp11) |=> $stable(q.cp11));
    // R8: forced SIMD disable reads one under Non-secure state
    assert_simd_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_state && grant.simd_dis) |-> rview[A_SIMD]);
endmodule

// File: rtl/cp_secgate.sv
`timescale 1ns/1ps
module cp_secgate
    import cp_secgate_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_sel,
    input  logic [31:0]   req_wdata,
    input  logic [1:0]    cur_el,
    input  logic          ns_state,
    input  logic          top_el_64,
    input  logic [1:0]    cp_use,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_trap,
    output logic          rsp_undef,
    output logic [1:0]    cp_ns_en,
    output logic          use_undef
);
    acc_kind_e     kind;
    grant_t        grant_q;
    grant_t        grant_w;
    cpacc_t        cpacc_q;
    cpacc_t        cpacc_w;
    logic [DW-1:0] cpacc_view;
    logic [DW-1:0] grant_view;
    logic [NUM_CP-1:0] grant_bits;
    logic [NUM_CP-1:0] use_hit;
    logic          unused_wdata;

    cp_secgate_decode u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_sel   (req_sel),
        .cur_el    (cur_el),
        .ns_state  (ns_state),
        .top_el_64 (top_el_64),
        .kind      (kind)
    );

    assign grant_w.simd_dis = req_wdata[G_SIMD];
    assign grant_w.cp11     = req_wdata[G_CP11];
    assign grant_w.cp10     = req_wdata[G_CP10];
    assign cpacc_w.simd_dis = req_wdata[A_SIMD];
    assign cpacc_w.cp11     = req_wdata[A_CP11_LO +: 2];
    assign cpacc_w.cp10     = req_wdata[A_CP10_LO +: 2];
    assign unused_wdata     = ^(req_wdata & ~(GRANT_MASK | CPACC_MASK));

    cp_secgate_grant u_grant (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (kind == ACC_WRITE && !req_sel),
        .wdata (grant_w),
        .q     (grant_q)
    );

    cp_secgate_cpacc u_cpacc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (kind == ACC_WRITE && req_sel),
        .wdata    (cpacc_w),
        .ns_state (ns_state),
        .grant    (grant_q),
        .q        (cpacc_q),
        .rview    (cpacc_view)
    );

    always_comb begin
        grant_view = '0;
        grant_view[G_SIMD] = grant_q.simd_dis;
        grant_view[G_CP11] = grant_q.cp11;
        grant_view[G_CP10] = grant_q.cp10;
    end

    assign grant_bits = {grant_q.cp11, grant_q.cp10};

    for (genvar i = 0; i < NUM_CP; i++) begin : g_cp
        assign cp_ns_en[i] = ns_state ? grant_bits[i] : 1'b1;
        assign use_hit[i]  = cp_use[i] & ~cp_ns_en[i];
    end
    assign use_undef = |use_hit;

    always_comb begin
        rsp_rdata = '0;
        rsp_trap  = 1'b0;
        rsp_undef = 1'b0;
        unique case (kind)
            ACC_NONE:     rsp_rdata = '0;
            ACC_READ:     rsp_rdata = req_sel ? cpacc_view : grant_view;
            ACC_WRITE:    rsp_rdata = '0;
            ACC_RD_FIXED: rsp_rdata = NS_FIXED_RD;
            ACC_TRAP:     rsp_trap  = 1'b1;
            ACC_UNDEF:    rsp_undef = 1'b1;
            default:      rsp_rdata = '0;
        endcase
    end

    // R3: EL0 accesses are refused
    assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el == 2'd0) |-> rsp_undef);
    // R3: refused or trapped writes leave both registers untouched
    assert_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (rsp_trap || rsp_undef)) |=> ($stable(grant_q) && $stable(cpacc_q)));
    // R5: a trap only arises for Secure EL1 grant accesses with a 64-bit top level
    assert_trap_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!ns_state && cur_el == 2'd1 && top_el_64 && !req_sel));
    // R6: Non-secure EL1/EL2 grant reads see the constant
    assert_fixed_rd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_sel && ns_state && top_el_64 && (cur_el == 2'd1 || cur_el == 2'd2))
        |-> (rsp_rdata == NS_FIXED_RD));
    // R2: grant reads never show reserved bits
    assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_sel && !ns_state) |-> ((rsp_rdata & ~GRANT_MASK) == '0));
    // R11: Secure state enables both coprocessors
    assert_secure_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ns_state |-> (cp_ns_en == 2'b11));
    // R13: no data on refused or trapped accesses
    assert_denied_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_trap || rsp_undef) |-> (rsp_rdata == '0));
endmodule

// File: tb/sim_cp_secgate.sv
`timescale 1ns/1ps
module sim_cp_secgate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cur_el = 2'd3;
    logic        ns_state = 1'b0;
    logic        top_el_64 = 1'b0;
    logic [1:0]  cp_use = 2'b00;
    logic [31:0] rsp_rdata;
    logic        rsp_trap;
    logic        rsp_undef;
    logic [1:0]  cp_ns_en;
    logic        use_undef;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // model state: grant {simd,cp11,cp10}, access {simd,cp11[1:0],cp10[1:0]}
    logic [2:0] mg = '0;
    logic [4:0] mc = '0;

    always #10 clk = ~clk;

    cp_secgate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .cur_el(cur_el), .ns_state(ns_state),
        .top_el_64(top_el_64), .cp_use(cp_use), .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap),
        .rsp_undef(rsp_undef), .cp_ns_en(cp_ns_en), .use_undef(use_undef)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] grant_word(input logic [2:0] g);
        return (32'(g[2]) << 15) | (32'(g[1]) << 11) | (32'(g[0]) << 10);
    endfunction

    task automatic access(input string tag, input logic [1:0] el, input logic ns, input logic t64,
                          input logic sel, input logic wr, input logic [31:0] wd);
        logic [31:0] er;
        logic et;
        logic eu;
        logic [2:0] ng;
        logic [4:0] nc;
        er = '0; et = 0; eu = 0; ng = mg; nc = mc;
        if (el == 2'd0) begin
            eu = 1;
        end else if (!sel) begin
            if (!ns && el == 2'd1 && t64) et = 1;
            else if (ns && wr) eu = 1;
            else if (wr) ng = {wd[15], wd[11], wd[10]};
            else if (ns && t64 && el != 2'd3) er = 32'h0000_0C00;
            else er = grant_word(mg);
        end else begin
            if (wr) begin
                if (!ns) nc = {wd[31], wd[23:22], wd[21:20]};
                else begin
                    if (mg[0]) nc[1:0] = wd[21:20];
                    if (mg[1]) nc[3:2] = wd[23:22];
                    if (!mg[2]) nc[4] = wd[31];
                end
            end else begin
                er[21:20] = (ns && !mg[0]) ? 2'b00 : mc[1:0];
                er[23:22] = (ns && !mg[1]) ? 2'b00 : mc[3:2];
                er[31]    = (ns && mg[2]) ? 1'b1 : mc[4];
            end
        end
        @(negedge clk);
        req_valid = 1; req_write = wr; req_sel = sel; req_wdata = wd;
        cur_el = el; ns_state = ns; top_el_64 = t64;
        #5;
        chk({tag, " rdata"}, rsp_rdata, er);
        chk({tag, " trap"}, {31'b0, rsp_trap}, {31'b0, et});
        chk({tag, " undef"}, {31'b0, rsp_undef}, {31'b0, eu});
        @(posedge clk);
        #1;
        req_valid = 0; req_write = 0;
        mg = ng; mc = nc;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        access("R1 grant reset", 2'd3, 0, 1, 0, 0, 0);
        access("R1 cpacc reset", 2'd3, 0, 1, 1, 0, 0);
        @(negedge clk);
        ns_state = 1; cp_use = 2'b00;
        #5 chk("R1 ns enables reset", {30'b0, cp_ns_en}, 32'd0);

        // R2: reserved bits of grant ignore writes; R10 next-cycle read
        access("R2 grant write all ones", 2'd3, 0, 0, 0, 1, 32'hFFFF_FFFF);
        access("R2 R10 grant readback", 2'd3, 0, 0, 0, 0, 0);
        access("R9 cpacc write all ones", 2'd3, 0, 0, 1, 1, 32'hFFFF_FFFF);
        access("R9 R10 cpacc readback", 2'd3, 0, 0, 1, 0, 0);

        // R11 R12: enables and coprocessor-use undefined per grant value
        for (int g = 0; g < 8; g++) begin
            access("R2 set grant", 2'd3, 0, 0, 0, 1, grant_word(3'(g)) | 32'hFFF0_73FF);
            for (int ns = 0; ns < 2; ns++) begin
                for (int u = 0; u < 4; u++) begin
                    logic [1:0] een;
                    logic [1:0] uu;
                    uu = 2'(u);
                    een = ns[0] ? {mg[1], mg[0]} : 2'b11;
                    @(negedge clk);
                    ns_state = ns[0]; cp_use = uu;
                    #5;
                    chk("R11 cp_ns_en", {30'b0, cp_ns_en}, {30'b0, een});
                    chk("R12 use_undef", {31'b0, use_undef}, {31'b0, |(uu & ~een)});
                end
            end
        end
        @(negedge clk);
        cp_use = 2'b00;

        // sweep: R3 R4 R5 R6 R7 R8 R9 R10 R13
        pat = 32'h1357_9BDF;
        for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 64; c++) begin
                logic [5:0] cc;
                cc = 6'(c);
                pat = pat * 32'h9E37_79B9 + 32'h7F4A_7C15;
                access("R4 establish grant", 2'd3, 0, 0, 0, 1, grant_word(3'(g)));
                access("R3 R4 R5 R6 R7 R8 R13 sweep access", cc[1:0], cc[2], cc[3], cc[4], cc[5], pat);
                access("R3 R4 R5 R10 grant readback", 2'd3, 0, 1, 0, 0, 0);
                access("R3 R7 R8 R9 R10 cpacc readback", 2'd3, 0, 1, 1, 0, 0);
                access("R7 R8 ns cpacc view", 2'd1, 1, cc[3], 1, 0, 0);
            end
        end

        // R13: idle cycle returns zero
        @(negedge clk);
        req_valid = 0;
        #5 chk("R13 idle rdata", rsp_rdata, 32'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule